// File: doc/BRIEF.md
# TDM Highway Time-Slot Port

This block connects a byte-oriented data path to one time slot of a serial TDM frame. A frame-sync input marks the start of every frame. The transmit and receive directions each run on their own bit clock. Each direction places its slot with three fields: a 3-bit bit offset, a 6-bit time-slot offset and a 6-bit slot number. The slot's first bit time is `bit_ofs + 8*ts_ofs + 8*slot_sel`, counted from the first bit time after frame sync.

On the transmit side, one byte is accepted per frame through a valid/ready handshake when frame sync is sampled. That byte is then shifted out during the assigned slot. At every other bit time the serial output is released to high impedance, and an active-low indicator marks the transmit slot. On the receive side, the eight bits of the receive slot are collected and delivered as one byte with a single-cycle valid strobe. Bytes go out and come in least significant bit first. When highway mode is on, each direction can be switched on its own to most significant bit first. The reversal applies to every byte, whatever its value. All placement and order settings are captured at frame sync and held for the whole frame.

Top module: `tdm_slot_port`

## Requirements
- R1: After reset, and until the first frame sync has been sampled, `slot_act_n` is 1, `tx_oe` is 0 and `rx_valid` is 0.
- R2: Bit time 0 is the bit-clock period that follows the rising edge at which `frame_sync` is sampled high. The transmit slot covers bit times Mt to Mt+7, where Mt = `tx_bit_ofs` + 8*`tx_ts_ofs` + 8*`tx_slot_sel`. During exactly those eight bit times `slot_act_n` is 0 and `tx_oe` is 1.
- R3: At every bit time outside the transmit slot, `tx_oe` is 0 and `tx_sd` is high impedance.
- R4: `tx_ready` is 1 exactly while `frame_sync` is 1. If `tx_valid` is 1 at the rising edge that samples frame sync, `tx_byte` is taken at that edge and sent in that frame's transmit slot.
- R5: If `tx_valid` is 0 at the sampled frame sync, the slot carries the idle byte 8'hFF.
- R6: In LSB-first order, slot bit k (k = 0 to 7) on `tx_sd` is bit k of the byte. On receive, slot bit k is stored in bit k of `rx_byte`.
- R7: With `hwy_en`=1 and `tx_lsb_first`=0, transmit slot bit k is bit 7-k of the byte.
- R8: The receive slot covers bit times Mr to Mr+7, with Mr formed from the receive fields in the same way as Mt. `rx_sd` is sampled on the rising edge that ends each of those bit times. `rx_valid` is 1 for exactly one bit time, bit time Mr+8, and `rx_byte` holds the assembled byte at that time.
- R9: With `hwy_en`=1 and `rx_lsb_first`=0, receive slot bit k is stored in bit 7-k of `rx_byte`. This setting is independent of the transmit order.
- R10: With `hwy_en`=0, `tx_lsb_first` and `rx_lsb_first` have no effect, and both directions use LSB-first order.
- R11: Offsets, slot numbers, `hwy_en` and both order bits are captured at the sampled frame sync. A change to them during a frame has no effect until the next frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Synchronous active-low reset, sampled by both bit clocks |
| tx_bclk | input | 1 | Transmit bit clock |
| rx_bclk | input | 1 | Receive bit clock |
| frame_sync | input | 1 | Frame start pulse, sampled on rising bit-clock edges |
| hwy_en | input | 1 | Highway mode; enables the order controls |
| tx_lsb_first | input | 1 | Transmit order, 1 = LSB first, 0 = reversed (highway mode only) |
| rx_lsb_first | input | 1 | Receive order, 1 = LSB first, 0 = reversed (highway mode only) |
| tx_bit_ofs | input | 3 | Transmit bit offset |
| tx_ts_ofs | input | 6 | Transmit time-slot offset |
| tx_slot_sel | input | 6 | Transmit slot number |
| rx_bit_ofs | input | 3 | Receive bit offset |
| rx_ts_ofs | input | 6 | Receive time-slot offset |
| rx_slot_sel | input | 6 | Receive slot number |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit byte accepted at this edge (high during frame sync) |
| tx_byte | input | 8 | Transmit byte |
| tx_sd | output | 1 | Serial transmit data, high impedance outside the slot |
| tx_oe | output | 1 | Transmit driver enable |
| slot_act_n | output | 1 | Active-low transmit slot indicator |
| rx_sd | input | 1 | Serial receive data |
| rx_valid | output | 1 | One-cycle strobe for a completed receive byte |
| rx_byte | output | 8 | Received byte |

## Verification
The bench drives inputs and samples outputs 1 ns after each rising edge, so each sample shows the bit time that edge opened. The edge that samples frame sync opens bit time 0. At bit time t the bench expects `tx_oe`, `slot_act_n` and the transmit bit for t in Mt..Mt+7 with no added latency. A receive bit is driven during its own bit time, so it is sampled by the edge that closes it. That makes `rx_valid` and `rx_byte` due at bit time Mr+8, one edge after the last slot bit. For every frame the bench computes Mt, Mr and the bit order of each direction from the settings in force at frame sync. In some frames it then scrambles the settings in mid-frame while keeping the expected values from that sync.

// File: rtl/tdm_pkg.sv
// Shared helpers for the TDM slot port.
// Assumes byte width is fixed per elaboration and passed as a parameter.
package tdm_pkg;

    // Index of the data bit carried at slot position pos; reversed order counts from the top.
    function automatic int unsigned slot_bit_pos(input int unsigned pos,
                                                 input logic msb_first,
                                                 input int unsigned width);
        return msb_first ? (width - 1 - pos) : pos;
    endfunction

endpackage

// File: rtl/tdm_slot_timer.sv
// Frame bit counter and slot window decode for one direction.
// Counts bit times from the edge that samples frame sync, captures the
// placement fields at that edge and flags the DW bit times of the slot.
// Assumes the sum of offsets fits the counter; the counter saturates.
module tdm_slot_timer #(
    parameter int BOF_W  = 3,
    parameter int TSO_W  = 6,
    parameter int SLOT_W = 6,
    parameter int DW     = 8,
    parameter int CNT_W  = 12,
    localparam int IDX_W = $clog2(DW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fs,
    input  logic [BOF_W-1:0]  bit_ofs,
    input  logic [TSO_W-1:0]  ts_ofs,
    input  logic [SLOT_W-1:0] slot_sel,
    output logic              in_slot,
    output logic [IDX_W-1:0]  bit_idx
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             framed_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] start_q;
    logic [CNT_W-1:0] start_d;
    logic [CNT_W-1:0] diff;

    // First bit time of the slot from the live fields, captured at sync.
    always_comb begin
        start_d = CNT_W'(bit_ofs) + CNT_W'(DW) * (CNT_W'(ts_ofs) + CNT_W'(slot_sel));
    end

    // Bit counter, placement capture and frame-seen flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            framed_q <= 1'b0;
            cnt_q    <= '0;
            start_q  <= '0;
        end else if (fs) begin
            framed_q <= 1'b1;
            cnt_q    <= '0;
            start_q  <= start_d;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Slot window decode and position inside the slot.
    always_comb begin
        diff    = cnt_q - start_q;
        in_slot = framed_q && (cnt_q >= start_q) && (diff < CNT_W'(DW));
        bit_idx = diff[IDX_W-1:0];
    end

    // R2: once a slot begins it runs through consecutive positions
    assert_slot_contig_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_slot && !fs && (bit_idx != IDX_W'(DW - 1))
        |=> in_slot && (bit_idx == $past(bit_idx) + 1'b1));

    // R2: a sampled sync restarts the frame at bit time zero
    assert_sync_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fs |=> (cnt_q == '0) && framed_q);

endmodule

// File: rtl/tdm_tx_lane.sv
// Transmit lane: takes one byte per frame at sync (or the idle pattern)
// and presents the bit for the current slot position in the captured order.
// Assumes in_slot/bit_idx come from a timer on the same clock.
module tdm_tx_lane #(
    parameter int DW     = 8,
    localparam int IDX_W = $clog2(DW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fs,
    input  logic             hwy_en,
    input  logic             lsb_first,
    input  logic             tx_valid,
    output logic             tx_ready,
    input  logic [DW-1:0]    tx_byte,
    input  logic             in_slot,
    input  logic [IDX_W-1:0] bit_idx,
    output logic             bit_out,
    output logic             oe
);
    import tdm_pkg::*;

    logic [DW-1:0] cur_q;
    logic          msb_q;

    // The byte is taken only on the edge that samples frame sync.
    always_comb tx_ready = fs;

    // Capture the frame's byte and bit order at sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '1;
            msb_q <= 1'b0;
        end else if (fs) begin
            cur_q <= tx_valid ? tx_byte : '1;
            msb_q <= hwy_en && !lsb_first;
        end
    end

    // Select the bit for this slot position.
    always_comb begin
        bit_out = cur_q[IDX_W'(slot_bit_pos(int'(bit_idx), msb_q, DW))];
        oe      = in_slot;
    end

    // R4: an offered byte at sync is the one held for the slot
    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fs && tx_valid |=> cur_q == $past(tx_byte));

    // R5: no offered byte at sync leaves the idle pattern
    assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fs && !tx_valid |=> cur_q == '1);

    // R10: order control is ignored outside highway mode
    assert_tx_order_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fs && !hwy_en |=> !msb_q);

endmodule

// File: rtl/tdm_rx_lane.sv
// Receive lane: samples the serial input at the edge that ends each slot
// bit time, assembles the byte in the captured order and strobes it out.
// Assumes in_slot/bit_idx come from a timer on the same clock.
module tdm_rx_lane #(
    parameter int DW     = 8,
    localparam int IDX_W = $clog2(DW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fs,
    input  logic             hwy_en,
    input  logic             lsb_first,
    input  logic             sd,
    input  logic             in_slot,
    input  logic [IDX_W-1:0] bit_idx,
    output logic             rx_valid,
    output logic [DW-1:0]    rx_byte
);
    import tdm_pkg::*;

    logic [DW-1:0] acc_q;
    logic [DW-1:0] acc_d;
    logic          msb_q;
    logic          last_bit;

    // Place the incoming bit into the partial byte.
    always_comb begin
        acc_d = acc_q;
        acc_d[IDX_W'(slot_bit_pos(int'(bit_idx), msb_q, DW))] = sd;
        last_bit = in_slot && (bit_idx == IDX_W'(DW - 1));
    end

    // Order capture at sync; accumulation and byte hand-off in the slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            msb_q    <= 1'b0;
            rx_valid <= 1'b0;
            rx_byte  <= '0;
        end else begin
            if (fs) msb_q <= hwy_en && !lsb_first;
            if (in_slot) acc_q <= acc_d;
            rx_valid <= last_bit;
            if (last_bit) rx_byte <= acc_d;
        end
    end

    // R8: a byte strobe follows the last slot bit and lasts one cycle
    assert_rx_after_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(in_slot) && ($past(bit_idx) == IDX_W'(DW - 1)));

    assert_rx_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R10: order control is ignored outside highway mode
    assert_rx_order_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fs && !hwy_en |=> !msb_q);

endmodule

// File: rtl/tdm_slot_port.sv
// TDM highway time-slot port. One timer per direction places the slot;
// the transmit lane drives the serial output only inside its slot and the
// receive lane returns one byte per frame.
// Assumes frame_sync is a single bit-time pulse visible to both clocks.
module tdm_slot_port #(
    parameter int BOF_W  = 3,
    parameter int TSO_W  = 6,
    parameter int SLOT_W = 6,
    parameter int DW     = 8,
    parameter int CNT_W  = 12
) (
    input  logic              rst_n,
    input  logic              tx_bclk,
    input  logic              rx_bclk,
    input  logic              frame_sync,
    input  logic              hwy_en,
    input  logic              tx_lsb_first,
    input  logic              rx_lsb_first,
    input  logic [BOF_W-1:0]  tx_bit_ofs,
    input  logic [TSO_W-1:0]  tx_ts_ofs,
    input  logic [SLOT_W-1:0] tx_slot_sel,
    input  logic [BOF_W-1:0]  rx_bit_ofs,
    input  logic [TSO_W-1:0]  rx_ts_ofs,
    input  logic [SLOT_W-1:0] rx_slot_sel,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [DW-1:0]     tx_byte,
    output logic              tx_sd,
    output logic              tx_oe,
    output logic              slot_act_n,
    input  logic              rx_sd,
    output logic              rx_valid,
    output logic [DW-1:0]     rx_byte
);
    localparam int IDX_W = $clog2(DW);

    logic             tx_in_slot;
    logic [IDX_W-1:0] tx_idx;
    logic             rx_in_slot;
    logic [IDX_W-1:0] rx_idx;
    logic             tx_bit;
    logic             tx_drive;

    tdm_slot_timer #(.BOF_W(BOF_W), .TSO_W(TSO_W), .SLOT_W(SLOT_W), .DW(DW), .CNT_W(CNT_W))
    u_tx_timer (
        .clk(tx_bclk), .rst_n(rst_n), .fs(frame_sync),
        .bit_ofs(tx_bit_ofs), .ts_ofs(tx_ts_ofs), .slot_sel(tx_slot_sel),
        .in_slot(tx_in_slot), .bit_idx(tx_idx)
    );

    tdm_slot_timer #(.BOF_W(BOF_W), .TSO_W(TSO_W), .SLOT_W(SLOT_W), .DW(DW), .CNT_W(CNT_W))
    u_rx_timer (
        .clk(rx_bclk), .rst_n(rst_n), .fs(frame_sync),
        .bit_ofs(rx_bit_ofs), .ts_ofs(rx_ts_ofs), .slot_sel(rx_slot_sel),
        .in_slot(rx_in_slot), .bit_idx(rx_idx)
    );

    tdm_tx_lane #(.DW(DW)) u_tx_lane (
        .clk(tx_bclk), .rst_n(rst_n), .fs(frame_sync),
        .hwy_en(hwy_en), .lsb_first(tx_lsb_first),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
        .in_slot(tx_in_slot), .bit_idx(tx_idx),
        .bit_out(tx_bit), .oe(tx_drive)
    );

    tdm_rx_lane #(.DW(DW)) u_rx_lane (
        .clk(rx_bclk), .rst_n(rst_n), .fs(frame_sync),
        .hwy_en(hwy_en), .lsb_first(rx_lsb_first), .sd(rx_sd),
        .in_slot(rx_in_slot), .bit_idx(rx_idx),
        .rx_valid(rx_valid), .rx_byte(rx_byte)
    );

    // Pin drive: serial data released outside the slot, indicator low inside.
    always_comb begin
        tx_oe      = tx_drive;
        slot_act_n = ~tx_in_slot;
    end
    assign tx_sd = tx_drive ? tx_bit : 1'bz;

    // R1: no slot activity before the first sync after reset
    assert_quiet_after_reset_R1: assert property (@(posedge tx_bclk) disable iff (!rst_n)
        $past(!rst_n) |-> slot_act_n && !tx_oe);

endmodule

// File: tb/sim_tdm_slot_port.sv
`timescale 1ns/1ps
module sim_tdm_slot_port;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n, frame_sync, hwy_en, tx_lsb_first, rx_lsb_first;
    logic [2:0] tx_bit_ofs, rx_bit_ofs;
    logic [5:0] tx_ts_ofs, tx_slot_sel, rx_ts_ofs, rx_slot_sel;
    logic       tx_valid, tx_ready, tx_sd, tx_oe, slot_act_n, rx_sd, rx_valid;
    logic [7:0] tx_byte, rx_byte;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    tdm_slot_port u0 (
        .rst_n(rst_n), .tx_bclk(clk), .rx_bclk(clk), .frame_sync(frame_sync),
        .hwy_en(hwy_en), .tx_lsb_first(tx_lsb_first), .rx_lsb_first(rx_lsb_first),
        .tx_bit_ofs(tx_bit_ofs), .tx_ts_ofs(tx_ts_ofs), .tx_slot_sel(tx_slot_sel),
        .rx_bit_ofs(rx_bit_ofs), .rx_ts_ofs(rx_ts_ofs), .rx_slot_sel(rx_slot_sel),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
        .tx_sd(tx_sd), .tx_oe(tx_oe), .slot_act_n(slot_act_n),
        .rx_sd(rx_sd), .rx_valid(rx_valid), .rx_byte(rx_byte)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (ok !== 1'b1) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // One frame: sync, then every bit time checked against M computed here.
    task automatic run_frame(input logic [2:0] tb, input logic [5:0] tt, input logic [5:0] ts,
                             input logic [2:0] rb, input logic [5:0] rt, input logic [5:0] rs,
                             input logic hw, input logic tl, input logic rl,
                             input logic txv, input logic [7:0] txd, input logic [7:0] rxd,
                             input bit perturb);
        int mt, mr, len;
        logic tx_msb, rx_msb;
        logic [7:0] sent;
        tx_bit_ofs = tb; tx_ts_ofs = tt; tx_slot_sel = ts;
        rx_bit_ofs = rb; rx_ts_ofs = rt; rx_slot_sel = rs;
        hwy_en = hw; tx_lsb_first = tl; rx_lsb_first = rl;
        frame_sync = 1'b1; tx_valid = txv; tx_byte = txd;
        #1;
        check(tx_ready == 1'b1, "R4 ready during sync", 32'(tx_ready), 1);
        @(posedge clk);
        #1;
        frame_sync = 1'b0; tx_valid = 1'b0; tx_byte = 8'h00;
        check(tx_ready == 1'b0, "R4 ready after sync", 32'(tx_ready), 0);
        mt = int'(tb) + 8 * (int'(tt) + int'(ts));
        mr = int'(rb) + 8 * (int'(rt) + int'(rs));
        len = ((mt > mr) ? mt : mr) + 10;
        tx_msb = hw && !tl;
        rx_msb = hw && !rl;
        sent = txv ? txd : 8'hFF;
        for (int t = 0; t < len; t++) begin
            logic in_tx, in_rx;
            if (perturb && t == 1) begin
                // R11: scramble every setting in mid-frame
                tx_bit_ofs = ~tb; tx_ts_ofs = tt + 6'd1; tx_slot_sel = ts + 6'd2;
                rx_bit_ofs = ~rb; rx_ts_ofs = rt + 6'd2; rx_slot_sel = rs + 6'd1;
                hwy_en = ~hw; tx_lsb_first = ~tl; rx_lsb_first = ~rl;
            end
            in_tx = (t >= mt) && (t < mt + 8);
            in_rx = (t >= mr) && (t < mr + 8);
            check(tx_oe == in_tx, perturb ? "R11 tx window held" : "R2/R3 tx_oe window",
                  32'(tx_oe), 32'(in_tx));
            check(slot_act_n == !in_tx, "R2 slot_act_n window", 32'(slot_act_n), 32'(!in_tx));
            if (in_tx) begin
                int k;
                logic eb;
                k = t - mt;
                eb = tx_msb ? sent[7 - k] : sent[k];
                check(tx_sd === eb,
                      !txv ? "R5 idle bit" : (tx_msb ? "R7 msb-first tx bit" :
                      (hw ? "R6 lsb-first tx bit" : "R10 tx order ignored")),
                      32'(tx_sd), 32'(eb));
            end
            check(rx_valid == (t == mr + 8), "R8 rx_valid timing", 32'(rx_valid), 32'(t == mr + 8));
            if (t == mr + 8)
                check(rx_byte == rxd,
                      rx_msb ? "R9 msb-first rx byte" : (hw ? "R6 rx byte" : "R10 rx order ignored"),
                      32'(rx_byte), 32'(rxd));
            if (in_rx) rx_sd = rx_msb ? rxd[7 - (t - mr)] : rxd[t - mr];
            else       rx_sd = 1'(t % 2);
            step();
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int frame;
        rst_n = 1'b0; frame_sync = 1'b0; hwy_en = 1'b0; tx_lsb_first = 1'b1; rx_lsb_first = 1'b1;
        tx_bit_ofs = 3'd0; tx_ts_ofs = 6'd0; tx_slot_sel = 6'd0;
        rx_bit_ofs = 3'd0; rx_ts_ofs = 6'd0; rx_slot_sel = 6'd0;
        tx_valid = 1'b0; tx_byte = 8'h00; rx_sd = 1'b0;
        repeat (4) step();
        rst_n = 1'b1;
        for (int i = 0; i < 12; i++) begin
            step();
            // R1: quiet before the first sync
            check(slot_act_n == 1'b1, "R1 slot_act_n idle", 32'(slot_act_n), 1);
            check(tx_oe == 1'b0, "R1 tx_oe idle", 32'(tx_oe), 0);
            check(rx_valid == 1'b0, "R1 rx_valid idle", 32'(rx_valid), 0);
            rx_sd = 1'(i % 2);
        end
        frame = 0;
        for (int mode = 0; mode < 5; mode++) begin
            logic hw, tl, rl;
            case (mode)
                0: begin hw = 1'b0; tl = 1'b0; rl = 1'b0; end
                1: begin hw = 1'b1; tl = 1'b1; rl = 1'b1; end
                2: begin hw = 1'b1; tl = 1'b0; rl = 1'b1; end
                3: begin hw = 1'b1; tl = 1'b1; rl = 1'b0; end
                default: begin hw = 1'b1; tl = 1'b0; rl = 1'b0; end
            endcase
            for (int b = 0; b < 8; b++) begin
                for (int s = 0; s < 4; s++) begin
                    logic [5:0] tso, sl;
                    tso = (s % 2 == 1) ? 6'd2 : 6'd0;
                    sl  = (s >= 2) ? 6'd3 : 6'd0;
                    run_frame(3'(b), tso, sl, 3'(7 - b), sl, tso + 6'd1,
                              hw, tl, rl, (frame % 5) != 4,
                              8'(8'h1D + frame * 37), 8'(8'hB4 ^ (frame * 13)),
                              (frame % 3) == 2);
                    frame++;
                end
            end
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule